// File: doc/BRIEF.md
# Dual Fetch Slot Selector by Queue Occupancy

This block decides, every clock, which two of eight hardware threads get to fetch instructions in the next cycle. Each thread reports how many instructions currently sit in its private instruction queue. Each thread also has an enable bit. The selector grants the two threads with the emptiest queues. The threads that are starved of work therefore get refilled first.

A thread is a candidate only when its enable bit is set and its queue can still accept a full fetch block, that is, its occupancy is at most the open limit. Among the candidates, the emptiest one goes to fetch port A and the next emptiest goes to fetch port B. Equal counts are resolved toward the lower thread number. For each port the block registers a valid flag, a thread number, a one-hot grant vector and the granted thread's program counter. The two program counters feed the two ports of the instruction cache directly.

Top module: `dual_fetch_picker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both ports show valid 0, thread number 0, one-hot grant 0 and PC 0.
- R2: Each output reflects the inputs sampled at the previous rising clock edge, exactly one cycle of latency. Input changes between edges do not alter the outputs.
- R3: A thread is a candidate only if its enable bit is 1 and its occupancy (5-bit unsigned) is 8 or less. Occupancies of 9 and above, including values above 16, exclude the thread.
- R4: Port A grants the candidate with the smallest occupancy. Among equal smallest occupancies, the lowest thread number wins.
- R5: Port B grants the candidate with the smallest occupancy after port A's thread is removed, using the same lowest-number rule for ties.
- R6: When both ports are valid they name different threads. Each port's one-hot grant has bit n set exactly when it grants thread n, and it is all zero when the port is invalid.
- R7: With exactly one candidate, only port A is valid. With no candidate, neither port is valid. Port B is never valid without port A.
- R8: A valid port's PC output equals the PC input of the granted thread, with thread n on bits n*32 to n*32+31 of the PC bus.
- R9: An invalid port drives thread number 0 and PC 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| occ_flat | input | 40 | Queue occupancy of thread n on bits 5n+4..5n |
| thr_enable | input | 8 | Per-thread fetch enable |
| thr_pc | input | 256 | Program counter of thread n on bits 32n+31..32n |
| a_valid | output | 1 | Port A grant valid |
| a_idx | output | 3 | Thread granted on port A |
| a_onehot | output | 8 | One-hot form of the port A grant |
| a_pc | output | 32 | PC of the port A thread |
| b_valid | output | 1 | Port B grant valid |
| b_idx | output | 3 | Thread granted on port B |
| b_onehot | output | 8 | One-hot form of the port B grant |
| b_pc | output | 32 | PC of the port B thread |

## Verification
The first patterns use strictly descending counts, which show whether the block really picks minima rather than the lowest thread numbers. Flat equal counts isolate the tie rule. Boundary sets with counts of exactly 8, 9 and 31, together with cleared enable bits, separate the exclusion rule from the ordering rule. These sets also produce the one-candidate and no-candidate cases. A long run of random counts, enables and PCs is compared every clock against a bench model that buckets threads by occupancy. Before each edge, the bench also confirms that the outputs still hold the previous result.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int FSEL_THREADS    = 8;
  localparam int FSEL_OCC_W      = 5;
  localparam int FSEL_PC_W       = 32;
  localparam int FSEL_OPEN_LIMIT = 8;
endpackage

// File: rtl/fsel_qualify.sv
module fsel_qualify #(
  parameter int NT    = 8,
  parameter int OCC_W = 5,
  parameter int LIMIT = 8
) (
  input  logic [NT*OCC_W-1:0] occ_flat,
  input  logic [NT-1:0]       enable,
  output logic [NT-1:0]       open_mask
);
  function automatic logic slot_open(input logic [OCC_W-1:0] cnt, input logic en);
    return en && (cnt <= OCC_W'(LIMIT));
  endfunction

  for (genvar g = 0; g < NT; g++) begin : g_thr
    assign open_mask[g] = slot_open(occ_flat[g*OCC_W +: OCC_W], enable[g]);
  end
endmodule

// File: rtl/fsel_min_pick.sv
module fsel_min_pick #(
  parameter int NT    = 8,
  parameter int OCC_W = 5,
  localparam int IDX_W = $clog2(NT)
) (
  input  logic [NT*OCC_W-1:0] occ_flat,
  input  logic [NT-1:0]       cand,
  output logic                found,
  output logic [IDX_W-1:0]    idx
);
  logic [OCC_W-1:0] best;

  // strict less-than while scanning upward: lower index keeps ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int t = 0; t < NT; t++) begin
      if (cand[t] && (!found || occ_flat[t*OCC_W +: OCC_W] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(t);
        best  = occ_flat[t*OCC_W +: OCC_W];
      end
    end
  end

  always_comb begin
    if (found) assert_pick_is_candidate_R3: assert (cand[idx]);
  end
endmodule

// File: rtl/dual_fetch_picker.sv
module dual_fetch_picker
  import fsel_pkg::*;
#(
  parameter int NT    = FSEL_THREADS,
  parameter int OCC_W = FSEL_OCC_W,
  parameter int PC_W  = FSEL_PC_W,
  parameter int LIMIT = FSEL_OPEN_LIMIT,
  localparam int IDX_W = $clog2(NT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NT*OCC_W-1:0] occ_flat,
  input  logic [NT-1:0]       thr_enable,
  input  logic [NT*PC_W-1:0]  thr_pc,
  output logic                a_valid,
  output logic [IDX_W-1:0]    a_idx,
  output logic [NT-1:0]       a_onehot,
  output logic [PC_W-1:0]     a_pc,
  output logic                b_valid,
  output logic [IDX_W-1:0]    b_idx,
  output logic [NT-1:0]       b_onehot,
  output logic [PC_W-1:0]     b_pc
);
  function automatic logic [NT-1:0] idx_to_onehot(input logic [IDX_W-1:0] i, input logic v);
    return v ? (NT'(1) << i) : '0;
  endfunction

  function automatic logic [PC_W-1:0] pc_of(input logic [NT*PC_W-1:0] bus,
                                            input logic [IDX_W-1:0] i, input logic v);
    return v ? bus[int'(i)*PC_W +: PC_W] : '0;
  endfunction

  // named internal events
  logic [NT-1:0]    open_mask;
  logic [NT-1:0]    cand_b;
  logic             win_a_found, win_b_found;
  logic [IDX_W-1:0] win_a_idx, win_b_idx;
  logic [OCC_W-1:0] win_a_occ, win_b_occ;

  fsel_qualify #(.NT(NT), .OCC_W(OCC_W), .LIMIT(LIMIT)) u_qual (
    .occ_flat (occ_flat),
    .enable   (thr_enable),
    .open_mask(open_mask)
  );

  fsel_min_pick #(.NT(NT), .OCC_W(OCC_W)) u_pick_a (
    .occ_flat(occ_flat),
    .cand    (open_mask),
    .found   (win_a_found),
    .idx     (win_a_idx)
  );

  assign cand_b = open_mask & ~idx_to_onehot(win_a_idx, win_a_found);

  fsel_min_pick #(.NT(NT), .OCC_W(OCC_W)) u_pick_b (
    .occ_flat(occ_flat),
    .cand    (cand_b),
    .found   (win_b_found),
    .idx     (win_b_idx)
  );

  assign win_a_occ = occ_flat[int'(win_a_idx)*OCC_W +: OCC_W];
  assign win_b_occ = occ_flat[int'(win_b_idx)*OCC_W +: OCC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid  <= 1'b0;
      a_idx    <= '0;
      a_onehot <= '0;
      a_pc     <= '0;
      b_valid  <= 1'b0;
      b_idx    <= '0;
      b_onehot <= '0;
      b_pc     <= '0;
    end else begin
      a_valid  <= win_a_found;
      a_idx    <= win_a_found ? win_a_idx : '0;
      a_onehot <= idx_to_onehot(win_a_idx, win_a_found);
      a_pc     <= pc_of(thr_pc, win_a_idx, win_a_found);
      b_valid  <= win_b_found;
      b_idx    <= win_b_found ? win_b_idx : '0;
      b_onehot <= idx_to_onehot(win_b_idx, win_b_found);
      b_pc     <= pc_of(thr_pc, win_b_idx, win_b_found);
    end
  end

  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_a_found && win_b_found) |-> (win_a_occ <= win_b_occ));

  assert_b_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_b_found |-> win_a_found);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_valid == $past(win_a_found)) && (b_valid == $past(win_b_found)));

  assert_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid) |-> (a_idx != b_idx));

  assert_onehot_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(a_onehot) == (a_valid ? 1 : 0));

  assert_onehot_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(b_onehot) == (b_valid ? 1 : 0));

  assert_b_needs_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> a_valid);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !b_valid |-> (b_idx == '0 && b_pc == '0));
endmodule

// File: tb/dual_fetch_picker_tb.sv
module dual_fetch_picker_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [39:0]  occ_flat = '0;
  logic [7:0]   thr_enable = '0;
  logic [255:0] thr_pc = '0;
  logic         a_valid, b_valid;
  logic [2:0]   a_idx, b_idx;
  logic [7:0]   a_onehot, b_onehot;
  logic [31:0]  a_pc, b_pc;

  int checks = 0;
  int errors = 0;

  int          occ_v [8];
  logic [7:0]  en_v;
  logic [31:0] pc_v  [8];
  bit          pa_v = 0, pb_v = 0;
  int          pa_i = 0, pb_i = 0;

  always #10 clk = ~clk;

  dual_fetch_picker u_dut (
    .clk(clk), .rst_n(rst_n), .occ_flat(occ_flat), .thr_enable(thr_enable),
    .thr_pc(thr_pc), .a_valid(a_valid), .a_idx(a_idx), .a_onehot(a_onehot),
    .a_pc(a_pc), .b_valid(b_valid), .b_idx(b_idx), .b_onehot(b_onehot), .b_pc(b_pc)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_port(input string nm, input bit v, input int i, input logic [7:0] oh,
                            input logic [31:0] pc, input bit ev, input int ei);
    logic [7:0]  eoh = ev ? (8'b1 << ei) : 8'h00;
    logic [31:0] epc = ev ? pc_v[ei] : 32'h0;
    int          eidx = ev ? ei : 0;
    chk(v == ev, {"R7 ", nm, " valid"}, longint'(v), longint'(ev));
    chk(i == eidx, ev ? {"R4/R5 ", nm, " thread"} : {"R9 ", nm, " thread"}, i, eidx);
    chk(oh == eoh, {"R6 ", nm, " onehot"}, oh, eoh);
    chk(pc == epc, ev ? {"R8 ", nm, " pc"} : {"R9 ", nm, " pc"}, pc, epc);
  endtask

  // one cycle: drive, check old result still held (R2), then check new result
  task automatic cycle();
    int order[$];
    bit ea_v, eb_v;
    int ea_i, eb_i;
    @(negedge clk);
    for (int t = 0; t < 8; t++) begin
      occ_flat[t*5 +: 5] = occ_v[t][4:0];
      thr_pc[t*32 +: 32] = pc_v[t];
    end
    thr_enable = en_v;
    // model: bucket candidates by occupancy, low thread first in each bucket (R3, R4, R5)
    for (int c = 0; c <= 8; c++)
      for (int t = 0; t < 8; t++)
        if (en_v[t] && (occ_v[t] % 32) == c) order.push_back(t);
    ea_v = order.size() > 0;
    eb_v = order.size() > 1;
    ea_i = ea_v ? order[0] : 0;
    eb_i = eb_v ? order[1] : 0;
    #1;
    chk(a_valid == pa_v && a_idx == pa_i, "R2 port A held before edge", a_idx, pa_i);
    chk(b_valid == pb_v && b_idx == pb_i, "R2 port B held before edge", b_idx, pb_i);
    @(posedge clk);
    #5;
    check_port("A", a_valid, a_idx, a_onehot, a_pc, ea_v, ea_i);
    check_port("B", b_valid, b_idx, b_onehot, b_pc, eb_v, eb_i);
    pa_v = ea_v; pa_i = ea_i; pb_v = eb_v; pb_i = eb_i;
  endtask

  task automatic fill_pcs();
    for (int t = 0; t < 8; t++) pc_v[t] = $urandom;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fill_pcs();
    for (int t = 0; t < 8; t++) occ_v[t] = 0;
    en_v = 8'hFF;
    repeat (3) @(posedge clk);
    #5;
    chk(!a_valid && !b_valid, "R1 valid in reset", {a_valid, b_valid}, 0);
    chk(a_onehot == 0 && b_onehot == 0, "R1 onehot in reset", {a_onehot, b_onehot}, 0);
    chk(a_pc == 0 && b_pc == 0 && a_idx == 0 && b_idx == 0, "R1 pc/idx in reset", a_pc, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 R5: descending counts, minima sit at the top thread numbers
    for (int t = 0; t < 8; t++) occ_v[t] = 7 - t;
    cycle();
    // R4 tie rule: all equal
    for (int t = 0; t < 8; t++) occ_v[t] = 3;
    fill_pcs();
    cycle();
    // R3 boundary: 8 open, 9 closed, 16 closed, single candidate (R7)
    for (int t = 0; t < 8; t++) occ_v[t] = 16;
    occ_v[5] = 8; occ_v[2] = 9;
    cycle();
    // R7 R9: no enables
    en_v = 8'h00;
    for (int t = 0; t < 8; t++) occ_v[t] = 0;
    cycle();
    // R3 enable masking: only threads 3 and 6 enabled
    en_v = 8'b0100_1000;
    occ_v[3] = 4; occ_v[6] = 2;
    cycle();
    // R3 out-of-range count 31 excluded
    en_v = 8'hFF;
    for (int t = 0; t < 8; t++) occ_v[t] = 16;
    occ_v[0] = 31; occ_v[7] = 0;
    cycle();
    // R5 second pick ties after first removed
    for (int t = 0; t < 8; t++) occ_v[t] = 6;
    occ_v[4] = 1;
    cycle();

    for (int n = 0; n < 600; n++) begin
      for (int t = 0; t < 8; t++) occ_v[t] = ($urandom % 4 == 0) ? ($urandom % 32) : ($urandom % 12);
      en_v = 8'($urandom) | 8'($urandom);
      if (n % 7 == 0) en_v = 8'($urandom) & 8'($urandom) & 8'($urandom);
      fill_pcs();
      cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule